// File: doc/BRIEF.md
# Numbered Subroutine Cache Controller

This block sits between a small processor core and its external program memory. The core names a subroutine by a short function number instead of an address. A table of start addresses, written before any call, translates that number. The instruction store is split into equal segments, and each segment holds the code of one function together with its own read pointer. A call to a function that is already resident switches to its segment at once. A call to a function that is not resident claims a segment and fills it through a valid/ready read port. The core stalls until that fill has finished.

A chain of active segments records the nesting of calls. A return pops the chain, and the caller resumes from the point its own pointer had reached. The segment chosen for a new function is the one called least recently that is not on the active chain. Calls the hardware cannot serve raise a one-cycle error flag and are dropped: a chain that is already full, a recursive call, or a return with nothing on the chain. Only this controller drives the external read port.

Top module: `ssc_top`

## Requirements
- R1: A write on the table port stores `tbl_addr` as the start address of function `tbl_idx`. A fill for that function requests `rd_addr` values from that start upward, one word for each accepted transfer, SEG_WORDS words in all.
- R2: Right after reset, `stall`, `rd_valid`, `act_valid` and `err` are 0 and `chain_depth` is 0. No segment holds valid code. The recency order runs from segment 0, called least recently, to segment SEGS-1.
- R3: A call that misses fills the segment called least recently among those not on the active chain. After reset, successive misses take segments 0, 1, 2 and so on in that order.
- R4: From the cycle after an accepted miss until the last word is accepted, `stall` is 1. While `rd_valid` is 1 and `rd_ready` is 0, `rd_addr` holds. `rd_valid` is never 1 outside a fill. The filled segment becomes active, with its pointer at 0, only after the last word.
- R5: A call to a function whose code is valid in a segment that is off the chain makes no external read. The call makes that segment active with its pointer at 0.
- R6: `instr` shows the word at the active segment's pointer, one cycle after the pointer or the active segment changes. A `step` pulse advances the active pointer by one and wraps to 0 after SEG_WORDS-1.
- R7: A return pops the chain. The caller's segment becomes active again with its pointer unchanged from before the call.
- R8: A call while SEGS functions are already on the chain pulses `err` for one cycle and changes nothing else.
- R9: A call to a function resident in a segment that is already on the chain (recursion) pulses `err` and changes nothing else.
- R10: A return while `chain_depth` is 0 pulses `err` and changes nothing else.
- R11: While `stall` is 1, `call_req`, `ret_req` and `step` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_wr | input | 1 | Write one address-table entry |
| tbl_idx | input | FN_W | Function number of the entry being written |
| tbl_addr | input | ADDR_W | External start address for that function |
| call_req | input | 1 | Call the function named by `call_fn` |
| call_fn | input | FN_W | Function number being called |
| ret_req | input | 1 | Return from the active function |
| step | input | 1 | Advance the active segment's pointer |
| stall | output | 1 | A segment fill is in progress |
| err | output | 1 | One-cycle pulse when a request is refused |
| act_valid | output | 1 | A function is active |
| act_seg | output | SEG_W | Segment of the active function |
| chain_depth | output | DEP_W | Number of functions on the call chain |
| instr | output | DATA_W | Code word at the active pointer |
| rd_valid | output | 1 | External read request |
| rd_addr | output | ADDR_W | External read address |
| rd_ready | input | 1 | External memory accepts the request; `rd_data` is valid |
| rd_data | input | DATA_W | Word returned by external memory |

## Verification
Directed sequences come first. One reaches a miss, a hit, a nested miss and a return, which separates the resident path from the fill path by counting external transfers. Further sequences fill the chain to its limit, call recursively and return with an empty chain, which separates each refusal from a real state change. A long random mix of calls over more functions than there are segments, with returns and pointer steps and a memory that withholds ready at random, follows. It tests that the recency order picks the right victim, that pinned segments survive, and that every word lands at its own offset.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  typedef enum logic {ST_IDLE, ST_FILL} ssc_state_e;
endpackage

// File: rtl/ssc_table.sv
module ssc_table #(
  parameter int N  = 32,
  parameter int IW = 5,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [AW-1:0] wdata,
  input  logic [IW-1:0] ridx,
  output logic [AW-1:0] rdata
);
  logic [AW-1:0] ent [N];

  always_ff @(posedge clk) begin
    if (we) ent[widx] <= wdata;
  end

  assign rdata = ent[ridx];
endmodule

// File: rtl/ssc_store.sv
module ssc_store #(
  parameter int DEPTH = 128,
  parameter int AW    = 7,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ssc_lru.sv
module ssc_lru #(
  parameter int SEGS = 8,
  parameter int SW   = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            touch,
  input  logic [SW-1:0]   touch_seg,
  input  logic [SEGS-1:0] pinned,
  output logic [SW-1:0]   victim
);
  logic [SW-1:0] age [SEGS];
  logic          found;
  logic [SW-1:0] best_age;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SEGS; i++) age[i] <= SW'(SEGS - 1 - i);
    end else if (touch) begin
      for (int i = 0; i < SEGS; i++) begin
        if (SW'(i) == touch_seg) age[i] <= '0;
        else if (age[i] < age[touch_seg]) age[i] <= age[i] + 1'b1;
      end
    end
  end

  always_comb begin
    found    = 1'b0;
    best_age = '0;
    victim   = '0;
    for (int i = 0; i < SEGS; i++) begin
      if (!pinned[i] && (!found || age[i] > best_age)) begin
        found    = 1'b1;
        best_age = age[i];
        victim   = SW'(i);
      end
    end
  end
endmodule

// File: rtl/ssc_stack.sv
module ssc_stack #(
  parameter int SEGS = 8,
  parameter int SW   = 3,
  parameter int DW   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic [SW-1:0]   push_seg,
  input  logic            pop,
  output logic [SW-1:0]   top,
  output logic [DW-1:0]   depth,
  output logic [SEGS-1:0] pinned
);
  logic [SW-1:0] ent [SEGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      depth <= '0;
      for (int i = 0; i < SEGS; i++) ent[i] <= '0;
    end else if (push) begin
      ent[SW'(depth)] <= push_seg;
      depth           <= depth + 1'b1;
    end else if (pop) begin
      depth <= depth - 1'b1;
    end
  end

  assign top = ent[SW'(depth - 1'b1)];

  always_comb begin
    pinned = '0;
    for (int k = 0; k < SEGS; k++) begin
      if (DW'(k) < depth) pinned[ent[k]] = 1'b1;
    end
  end
endmodule

// File: rtl/ssc_top.sv
module ssc_top
  import ssc_pkg::*;
#(
  parameter int FN_CNT    = 32,
  parameter int SEGS      = 8,
  parameter int SEG_WORDS = 16,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  localparam int FN_W  = $clog2(FN_CNT),
  localparam int SEG_W = $clog2(SEGS),
  localparam int OFS_W = $clog2(SEG_WORDS),
  localparam int DEP_W = $clog2(SEGS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tbl_wr,
  input  logic [FN_W-1:0]   tbl_idx,
  input  logic [ADDR_W-1:0] tbl_addr,
  input  logic              call_req,
  input  logic [FN_W-1:0]   call_fn,
  input  logic              ret_req,
  input  logic              step,
  output logic              stall,
  output logic              err,
  output logic              act_valid,
  output logic [SEG_W-1:0]  act_seg,
  output logic [DEP_W-1:0]  chain_depth,
  output logic [DATA_W-1:0] instr,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ready,
  input  logic [DATA_W-1:0] rd_data
);
  localparam logic [OFS_W-1:0] LAST_OFS = OFS_W'(SEG_WORDS - 1);

  ssc_state_e        state;
  logic [SEGS-1:0]   seg_vld;
  logic [FN_W-1:0]   seg_fn [SEGS];
  logic [OFS_W-1:0]  ptr    [SEGS];
  logic [OFS_W-1:0]  cnt;
  logic [SEG_W-1:0]  fill_seg;
  logic [ADDR_W-1:0] base_addr;
  logic [SEG_W-1:0]  top, victim, hit_seg, push_seg;
  logic [DEP_W-1:0]  depth;
  logic [SEGS-1:0]   pinned;
  logic              hit, idle, full;
  logic              call_go, call_bad, call_hit, call_miss;
  logic              ret_go, ret_bad, ret_ok, step_go;
  logic              fill_acc, fill_done, push;

  ssc_table #(.N(FN_CNT), .IW(FN_W), .AW(ADDR_W)) u_table (
    .clk(clk), .we(tbl_wr), .widx(tbl_idx), .wdata(tbl_addr),
    .ridx(call_fn), .rdata(base_addr)
  );

  ssc_stack #(.SEGS(SEGS), .SW(SEG_W), .DW(DEP_W)) u_stack (
    .clk(clk), .rst(rst), .push(push), .push_seg(push_seg), .pop(ret_ok),
    .top(top), .depth(depth), .pinned(pinned)
  );

  ssc_lru #(.SEGS(SEGS), .SW(SEG_W)) u_lru (
    .clk(clk), .rst(rst), .touch(push), .touch_seg(push_seg),
    .pinned(pinned), .victim(victim)
  );

  ssc_store #(.DEPTH(SEGS * SEG_WORDS), .AW(SEG_W + OFS_W), .DW(DATA_W)) u_store (
    .clk(clk), .we(fill_acc), .waddr({fill_seg, cnt}), .wdata(rd_data),
    .raddr({top, ptr[top]}), .rdata(instr)
  );

  always_comb begin
    hit     = 1'b0;
    hit_seg = '0;
    for (int i = 0; i < SEGS; i++) begin
      if (seg_vld[i] && seg_fn[i] == call_fn) begin
        hit     = 1'b1;
        hit_seg = SEG_W'(i);
      end
    end
  end

  assign idle      = (state == ST_IDLE);
  assign full      = (depth == DEP_W'(SEGS));
  assign call_go   = idle && call_req;
  assign call_bad  = call_go && (full || (hit && pinned[hit_seg]));
  assign call_hit  = call_go && !call_bad && hit;
  assign call_miss = call_go && !call_bad && !hit;
  assign ret_go    = idle && !call_req && ret_req;
  assign ret_bad   = ret_go && (depth == '0);
  assign ret_ok    = ret_go && (depth != '0);
  assign step_go   = idle && !call_req && !ret_req && step && (depth != '0);
  assign fill_acc  = (state == ST_FILL) && rd_valid && rd_ready;
  assign fill_done = fill_acc && (cnt == LAST_OFS);
  assign push      = call_hit || fill_done;
  assign push_seg  = call_hit ? hit_seg : fill_seg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      seg_vld  <= '0;
      cnt      <= '0;
      fill_seg <= '0;
      rd_valid <= 1'b0;
      rd_addr  <= '0;
      err      <= 1'b0;
      for (int i = 0; i < SEGS; i++) begin
        ptr[i]    <= '0;
        seg_fn[i] <= '0;
      end
    end else begin
      err <= call_bad || ret_bad;
      if (call_hit) ptr[hit_seg] <= '0;
      if (step_go) ptr[top] <= (ptr[top] == LAST_OFS) ? '0 : ptr[top] + 1'b1;
      if (call_miss) begin
        state            <= ST_FILL;
        fill_seg         <= victim;
        seg_vld[victim]  <= 1'b0;
        seg_fn[victim]   <= call_fn;
        cnt              <= '0;
        rd_valid         <= 1'b1;
        rd_addr          <= base_addr;
      end
      if (fill_acc) begin
        if (fill_done) begin
          state             <= ST_IDLE;
          rd_valid          <= 1'b0;
          seg_vld[fill_seg] <= 1'b1;
          ptr[fill_seg]     <= '0;
        end else begin
          cnt     <= cnt + 1'b1;
          rd_addr <= rd_addr + 1'b1;
        end
      end
    end
  end

  assign stall       = (state == ST_FILL);
  assign act_valid   = (depth != '0);
  assign act_seg     = top;
  assign chain_depth = depth;
endmodule

// File: rtl/ssc_chk.sv
module ssc_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              stall,
  input logic              err,
  input logic              act_valid,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [ADDR_W-1:0] rd_addr
);
  // R4
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

  // R1
  rd_seq_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid && rd_ready |=> !rd_valid || (rd_addr == $past(rd_addr) + 1'b1));

  // R4
  rd_in_fill_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> stall);

  // R4
  fill_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(stall) |-> act_valid);

  // R11
  no_err_in_fill_chk: assert property (@(posedge clk) disable iff (rst)
    stall |-> !err);
endmodule

bind ssc_top ssc_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .stall(stall), .err(err), .act_valid(act_valid),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr)
);

// File: tb/ssc_top_bench.sv
module ssc_top_bench;
  localparam int FN_CNT = 32, SEGS = 8, SW = 16, AW = 16, DW = 16;
  localparam int FN_W = 5, SEG_W = 3, DEP_W = 4;

  logic clk = 0, rst = 1;
  logic tbl_wr = 0, call_req = 0, ret_req = 0, step = 0, rd_ready = 0;
  logic [FN_W-1:0] tbl_idx = '0, call_fn = '0;
  logic [AW-1:0] tbl_addr = '0;
  logic stall, err, act_valid, rd_valid;
  logic [SEG_W-1:0] act_seg;
  logic [DEP_W-1:0] chain_depth;
  logic [DW-1:0] instr, rd_data;
  logic [AW-1:0] rd_addr;

  int checks = 0, failures = 0, xfers = 0, cyc = 0;
  int m_tbl [FN_CNT];
  bit m_vld [SEGS];
  int m_fn [SEGS], m_age [SEGS], m_stk [SEGS], m_ptr [SEGS];
  int m_dep = 0;

  ssc_top #(.FN_CNT(FN_CNT), .SEGS(SEGS), .SEG_WORDS(SW), .ADDR_W(AW), .DATA_W(DW)) u_ssc_top (
    .clk(clk), .rst(rst), .tbl_wr(tbl_wr), .tbl_idx(tbl_idx), .tbl_addr(tbl_addr),
    .call_req(call_req), .call_fn(call_fn), .ret_req(ret_req), .step(step),
    .stall(stall), .err(err), .act_valid(act_valid), .act_seg(act_seg),
    .chain_depth(chain_depth), .instr(instr), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .rd_ready(rd_ready), .rd_data(rd_data)
  );

  always #5 clk = ~clk;

  function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
    return DW'(a * 16'd7) ^ 16'h5A3C;
  endfunction

  assign rd_data = memf(rd_addr);

  always @(negedge clk) rd_ready <= ($urandom % 4) != 0;
  always @(posedge clk) if (!rst && rd_valid && rd_ready) xfers++;

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int m_find(input int fn);
    for (int s = 0; s < SEGS; s++) if (m_vld[s] && m_fn[s] == fn) return s;
    return -1;
  endfunction

  function automatic bit m_pinned(input int s);
    for (int k = 0; k < m_dep; k++) if (m_stk[k] == s) return 1;
    return 0;
  endfunction

  function automatic int m_victim();
    int best = -1;
    for (int s = 0; s < SEGS; s++)
      if (!m_pinned(s) && (best < 0 || m_age[s] > m_age[best])) best = s;
    return best;
  endfunction

  task automatic m_touch(input int s);
    for (int i = 0; i < SEGS; i++)
      if (i != s && m_age[i] < m_age[s]) m_age[i]++;
    m_age[s] = 0;
  endtask

  task automatic check_state(input string req);
    chk({req, " depth"}, int'(chain_depth), m_dep);
    chk({req, " act_valid"}, int'(act_valid), int'(m_dep > 0));
    if (m_dep > 0) begin
      int s = m_stk[m_dep - 1];
      chk({req, " act_seg"}, int'(act_seg), s);
      chk({req, " instr"}, int'(instr), int'(memf(AW'(m_tbl[m_fn[s]] + m_ptr[s]))));
    end
  endtask

  task automatic wait_idle();
    int g = 0;
    while (stall && g < 2000) begin @(negedge clk); g++; end
    @(negedge clk);
  endtask

  task automatic do_load(input int idx, input int addr);
    @(negedge clk);
    tbl_wr = 1; tbl_idx = FN_W'(idx); tbl_addr = AW'(addr);
    @(negedge clk);
    tbl_wr = 0;
    m_tbl[idx] = addr;
  endtask

  task automatic do_call(input int fn, input bit poke);
    int hs = m_find(fn);
    bit full = (m_dep == SEGS);
    bit rec = !full && hs >= 0 && m_pinned(hs);
    bit bad = full || rec;
    bit miss = !bad && hs < 0;
    int seg = bad ? -1 : (hs >= 0 ? hs : m_victim());
    int x0 = xfers;
    @(negedge clk);
    call_req = 1; call_fn = FN_W'(fn);
    @(negedge clk);
    call_req = 0;
    chk(full ? "R8 err" : (rec ? "R9 err" : "R3 no err"), int'(err), int'(bad));
    if (miss) chk("R4 stall during fill", int'(stall), 1);
    if (poke && miss) begin
      ret_req = 1; step = 1; call_req = 1; call_fn = FN_W'(fn ^ 1);
      @(negedge clk);
      ret_req = 0; step = 0; call_req = 0;
    end
    wait_idle();
    if (!bad) begin
      m_vld[seg] = 1; m_fn[seg] = fn; m_ptr[seg] = 0;
      m_stk[m_dep] = seg; m_dep++;
      m_touch(seg);
    end
    chk(miss ? "R1 fill words" : "R5 no external read", xfers - x0, miss ? SW : 0);
    check_state(poke ? "R11" : (miss ? "R3" : "R5"));
  endtask

  task automatic do_ret();
    bit bad = (m_dep == 0);
    @(negedge clk);
    ret_req = 1;
    @(negedge clk);
    ret_req = 0;
    chk(bad ? "R10 err" : "R7 no err", int'(err), int'(bad));
    if (!bad) m_dep--;
    @(negedge clk);
    check_state(bad ? "R10" : "R7");
  endtask

  task automatic do_step();
    @(negedge clk);
    step = 1;
    @(negedge clk);
    step = 0;
    if (m_dep > 0) m_ptr[m_stk[m_dep - 1]] = (m_ptr[m_stk[m_dep - 1]] + 1) % SW;
    @(negedge clk);
    check_state("R6");
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < SEGS; i++) begin
      m_vld[i] = 0; m_fn[i] = 0; m_ptr[i] = 0; m_stk[i] = 0; m_age[i] = SEGS - 1 - i;
    end
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R2 stall", int'(stall), 0);
    chk("R2 rd_valid", int'(rd_valid), 0);
    chk("R2 act_valid", int'(act_valid), 0);
    chk("R2 err", int'(err), 0);
    chk("R2 depth", int'(chain_depth), 0);

    for (int i = 0; i < FN_CNT; i++) do_load(i, 16'h0033 + i * 16'h0100 + i * 3);

    do_call(3, 1);
    chk("R3 first victim", int'(act_seg), 0);
    for (int k = 0; k < 3; k++) do_step();
    do_call(5, 0);
    chk("R3 second victim", int'(act_seg), 1);
    do_call(3, 0);
    do_ret();
    chk("R7 caller segment", int'(act_seg), 0);
    do_ret();
    do_ret();
    do_call(3, 0);
    chk("R5 hit segment", int'(act_seg), 0);
    for (int k = 0; k < SW + 1; k++) do_step();
    do_ret();

    for (int f = 10; f < 10 + SEGS; f++) do_call(f, 0);
    do_call(20, 0);
    for (int k = 0; k < SEGS + 1; k++) do_ret();

    for (int n = 0; n < 400; n++) begin
      int r = $urandom % 10;
      if (r < 5) do_call($urandom % 12, 0);
      else if (r < 8) do_ret();
      else do_step();
    end

    summary();
    $finish;
  end
endmodule